// File: doc/BRIEF.md
# Mailbox Background Command Tracker

This block follows a single long-running mailbox command inside a memory-expander device controller. A command decoder presents a start request with a command-set byte, a command byte and a runtime in milliseconds. If no background command is running, the request is accepted: the tracker answers "background started", raises the background-running flag of the mailbox status register and publishes a background status word holding the 16-bit opcode, a percentage of 0 and a return code. A request that arrives while another command is still running is answered with a busy code and changes nothing.

A free-running one-millisecond tick drives the elapsed time. Once every update period (1000 ms by default) the tracker recomputes the percentage complete as elapsed x 100 / runtime with a short serial divider, capped at 99 so that 100 is never shown early. On the tick where the elapsed time reaches the runtime, the tracker reports 100 percent and a success code, clears the running flag, emits a one-cycle completion pulse carrying the finished opcode, and raises a completion interrupt request on a fixed message vector. The tracker also gives the packed word returned by a status query.

The response strobe `rsp_valid` doubles as the foreground-done indication, which clears the host doorbell. `bg_running` is the background-operation bit of the mailbox status register.

Top module: `bgt_tracker`

## Requirements
- R1: After reset, `bg_running`, `bg_pct`, `bg_opcode`, `bg_retcode`, `done_pulse`, `irq_msix` and `irq_msi` are all zero.
- R2: A `start_req` seen while idle is accepted. One cycle later `rsp_valid` is 1, `rsp_code` is 0x0001 (background started), `bg_running` is 1, `bg_opcode` is {`start_set`, `start_cmd`} (set byte in bits 15:8), `bg_pct` is 0 and `bg_retcode` is 0x0001.
- R3: A `start_req` seen while `bg_running` is 1 gets `rsp_valid` with `rsp_code` 0x0010 (busy) one cycle later. It leaves `bg_opcode`, `bg_pct` and `bg_running` unchanged.
- R4: On each tick that brings the elapsed time to a nonzero multiple of UPD_MS without reaching the runtime, `bg_pct` becomes min(99, floor(elapsed x 100 / runtime)) within 9 cycles. Other ticks before the finish leave `bg_pct` unchanged. While `bg_running` is 1, `bg_pct` never exceeds 99.
- R5: On the tick that brings the elapsed time to the runtime, the next cycle shows `bg_running` 0, `bg_pct` 100 and `bg_retcode` 0x0000 (success). It also shows `done_pulse` high for exactly one cycle, with `done_opcode` equal to the finished opcode.
- R6: `qry_status` has bit 0 equal to `bg_running` and bits 7:1 equal to `bg_pct`.
- R7: At completion, `irq_msix` pulses for one cycle if `msix_en` is 1. Otherwise `irq_msi` pulses if `msi_en` is 1. Otherwise neither pulses. `irq_vector` is constant 9 and `cap_bg_irq` is constant 1.
- R8: A start request with a runtime of 0 is treated as a runtime of 1 ms.
- R9: A tick in the same cycle as an accepted start is not counted. Elapsed time starts at 0 after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| start_req | input | 1 | Start request for a background-capable command |
| start_set | input | 8 | Command-set byte |
| start_cmd | input | 8 | Command byte |
| start_runtime | input | RT_W | Runtime in milliseconds |
| msix_en | input | 1 | MSI-X delivery enabled |
| msi_en | input | 1 | MSI delivery enabled |
| rsp_valid | output | 1 | Foreground response strobe (doorbell clear) |
| rsp_code | output | 16 | Foreground return code |
| bg_running | output | 1 | Background-operation bit of mailbox status |
| bg_opcode | output | 16 | Opcode of the current or last background command |
| bg_pct | output | 7 | Percentage complete |
| bg_retcode | output | 16 | Background return code |
| qry_status | output | 8 | Packed status-query word |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_opcode | output | 16 | Opcode that just finished |
| irq_msix | output | 1 | Completion request over MSI-X |
| irq_msi | output | 1 | Completion request over MSI |
| irq_vector | output | 5 | Message vector number (9) |
| cap_bg_irq | output | 1 | Capability: background completion interrupt |

## Verification
Start responses, busy responses, the finish state, the completion pulse and the interrupt requests all appear in the first cycle after the edge that samples the stimulus. The bench therefore drives on the falling edge and checks at the very next falling edge. A progress update goes through a seven-step divider and is due within 9 cycles of its tick. The bench waits 10 falling edges after every non-final tick before comparing `bg_pct` against its own floor(e x 100 / rt) model, so the value is checked only after the divider has settled. Ticks are spaced 12 cycles apart, and busy requests are issued only after that settling window.

// File: rtl/bgt_pkg.sv
// Package: shared return codes and helpers for the background tracker.
// Assumes 16-bit return codes and a 7-bit percentage field.
package bgt_pkg;
    localparam logic [15:0] RC_SUCCESS    = 16'h0000;
    localparam logic [15:0] RC_BG_STARTED = 16'h0001;
    localparam logic [15:0] RC_BUSY       = 16'h0010;
    localparam int          PCT_W         = 7;
    localparam logic [6:0]  PCT_FULL      = 7'd100;
    localparam logic [6:0]  PCT_CAP       = 7'd99;

    // Cap an intermediate percentage so 100 only ever comes from the finish path.
    function automatic logic [6:0] cap_pct(input logic [6:0] q);
        return (q > PCT_CAP) ? PCT_CAP : q;
    endfunction
endpackage

// File: rtl/bgt_timebase.sv
// Module: millisecond bookkeeping for the running command.
// Counts elapsed ticks and the update-period phase. It flags the finish tick
// and the progress-update ticks. Assumes UPD_MS >= 1 and runtime >= 1.
module bgt_timebase #(
    parameter int RT_W   = 24,
    parameter int UPD_MS = 1000,
    localparam int PW    = $clog2(UPD_MS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic            tick,
    input  logic [RT_W-1:0] runtime,
    output logic            finish,
    output logic            launch,
    output logic [RT_W-1:0] elapsed_nxt
);
    logic [RT_W-1:0] elapsed_q;
    logic [PW-1:0]   phase_q;
    logic            phase_wrap;

    // Next elapsed value and the period boundary.
    always_comb begin
        elapsed_nxt = elapsed_q + 1'b1;
        phase_wrap  = (phase_q == PW'(UPD_MS - 1));
        finish      = run && tick && (elapsed_nxt >= runtime);
        launch      = run && tick && !finish && phase_wrap;
    end

    // Elapsed and phase counters: cleared on start, advanced on counted ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            elapsed_q <= '0;
            phase_q   <= '0;
        end else if (run && tick) begin
            elapsed_q <= elapsed_nxt;
            phase_q   <= phase_wrap ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/bgt_pct_div.sv
// Module: serial divider for progress percentage.
// Computes floor(num / den) when the quotient is known to be below 128.
// It preloads num >> 7 as the partial remainder, then resolves one quotient
// bit per cycle over 7 cycles. Assumes num < 128 * den and den >= 1.
module bgt_pct_div #(
    parameter int RT_W = 24,
    localparam int NW  = RT_W + 7,
    localparam int QW  = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            abort,
    input  logic [NW-1:0]   num,
    input  logic [RT_W-1:0] den,
    output logic            done,
    output logic [QW-1:0]   quot
);
    logic [RT_W-1:0] rem_q;
    logic [QW-1:0]   low_q;
    logic [2:0]      cnt_q;
    logic            busy_q;
    logic [RT_W:0]   trial;
    logic            take;

    // One restoring step: bring in the next numerator bit and compare.
    always_comb begin
        trial = {rem_q, low_q[QW-1]};
        take  = (trial >= {1'b0, den});
    end

    // Step sequencer: load on go, shift quotient bits, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            rem_q  <= '0;
            low_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
            quot   <= '0;
        end else if (go) begin
            rem_q  <= num[NW-1:QW];
            low_q  <= num[QW-1:0];
            cnt_q  <= 3'(QW);
            busy_q <= 1'b1;
            done   <= 1'b0;
            quot   <= '0;
        end else if (busy_q) begin
            rem_q  <= take ? RT_W'(trial - {1'b0, den}) : trial[RT_W-1:0];
            low_q  <= {low_q[QW-2:0], 1'b0};
            quot   <= {quot[QW-2:0], take};
            cnt_q  <= cnt_q - 1'b1;
            busy_q <= (cnt_q != 3'd1);
            done   <= (cnt_q == 3'd1);
        end else begin
            done   <= 1'b0;
        end
    end
endmodule

// File: rtl/bgt_irq_sel.sv
// Module: completion interrupt request selection.
// Routes a completion event to MSI-X when enabled, else to MSI, else drops it.
// Outputs are registered one-cycle pulses.
module bgt_irq_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic msix_en,
    input  logic msi_en,
    output logic irq_msix,
    output logic irq_msi
);
    // Register the selected request for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_msix <= 1'b0;
            irq_msi  <= 1'b0;
        end else begin
            irq_msix <= fire && msix_en;
            irq_msi  <= fire && !msix_en && msi_en;
        end
    end
endmodule

// File: rtl/bgt_tracker.sv
// Module: background command tracker (top).
// Accepts one background command at a time and refuses overlaps with a busy
// code. It tracks progress from a millisecond tick and publishes opcode,
// percentage and return code. At completion it clears the running bit and
// raises a done pulse and an interrupt request. Assumes ms_tick is a
// single-cycle pulse spaced at least 9 cycles apart.
module bgt_tracker
    import bgt_pkg::*;
#(
    parameter int          RT_W   = 24,
    parameter int          UPD_MS = 1000,
    parameter int          VEC_W  = 5,
    parameter logic [4:0]  IRQ_VEC = 5'd9,
    localparam int         NW     = RT_W + 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             start_req,
    input  logic [7:0]       start_set,
    input  logic [7:0]       start_cmd,
    input  logic [RT_W-1:0]  start_runtime,
    input  logic             msix_en,
    input  logic             msi_en,
    output logic             rsp_valid,
    output logic [15:0]      rsp_code,
    output logic             bg_running,
    output logic [15:0]      bg_opcode,
    output logic [6:0]       bg_pct,
    output logic [15:0]      bg_retcode,
    output logic [7:0]       qry_status,
    output logic             done_pulse,
    output logic [15:0]      done_opcode,
    output logic             irq_msix,
    output logic             irq_msi,
    output logic [VEC_W-1:0] irq_vector,
    output logic             cap_bg_irq
);
    logic            accept;
    logic            finish;
    logic            launch;
    logic [RT_W-1:0] elapsed_nxt;
    logic [RT_W-1:0] runtime_q;
    logic            div_done;
    logic [6:0]      div_quot;
    logic [NW-1:0]   div_num;

    // Start is accepted only while no background command is running.
    always_comb begin
        accept  = start_req && !bg_running;
        div_num = NW'(elapsed_nxt) * NW'(100);
    end

    bgt_timebase #(.RT_W(RT_W), .UPD_MS(UPD_MS)) u_time (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (accept),
        .run         (bg_running),
        .tick        (ms_tick),
        .runtime     (runtime_q),
        .finish      (finish),
        .launch      (launch),
        .elapsed_nxt (elapsed_nxt)
    );

    bgt_pct_div #(.RT_W(RT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (launch),
        .abort (accept || finish),
        .num   (div_num),
        .den   (runtime_q),
        .done  (div_done),
        .quot  (div_quot)
    );

    bgt_irq_sel u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (finish),
        .msix_en  (msix_en),
        .msi_en   (msi_en),
        .irq_msix (irq_msix),
        .irq_msi  (irq_msi)
    );

    // Foreground response: started or busy, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RC_SUCCESS;
        end else begin
            rsp_valid <= start_req;
            if (start_req) rsp_code <= bg_running ? RC_BUSY : RC_BG_STARTED;
        end
    end

    // Background state: running bit, runtime, opcode, percentage, return code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bg_running <= 1'b0;
            runtime_q  <= '0;
            bg_opcode  <= '0;
            bg_pct     <= '0;
            bg_retcode <= RC_SUCCESS;
        end else if (accept) begin
            bg_running <= 1'b1;
            runtime_q  <= (start_runtime == '0) ? RT_W'(1) : start_runtime;
            bg_opcode  <= {start_set, start_cmd};
            bg_pct     <= '0;
            bg_retcode <= RC_BG_STARTED;
        end else if (finish) begin
            bg_running <= 1'b0;
            runtime_q  <= '0;
            bg_pct     <= PCT_FULL;
            bg_retcode <= RC_SUCCESS;
        end else if (div_done && bg_running) begin
            bg_pct     <= cap_pct(div_quot);
        end
    end

    // Completion strobe carrying the finished opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse  <= 1'b0;
            done_opcode <= '0;
        end else begin
            done_pulse <= finish;
            if (finish) done_opcode <= bg_opcode;
        end
    end

    // Status-query word and constant capability outputs.
    always_comb begin
        qry_status = {bg_pct, bg_running};
        irq_vector = VEC_W'(IRQ_VEC);
        cap_bg_irq = 1'b1;
    end
endmodule

// File: rtl/bgt_tracker_chk.sv
// Module: property checker for the background tracker, attached by bind.
// Observes top-level ports only.
module bgt_tracker_chk
    import bgt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_req,
    input logic [7:0]  start_set,
    input logic [7:0]  start_cmd,
    input logic        rsp_valid,
    input logic [15:0] rsp_code,
    input logic        bg_running,
    input logic [15:0] bg_opcode,
    input logic [6:0]  bg_pct,
    input logic [15:0] bg_retcode,
    input logic        done_pulse,
    input logic [15:0] done_opcode,
    input logic        irq_msix,
    input logic        irq_msi
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !bg_running) |=> (bg_running && rsp_valid &&
        rsp_code == RC_BG_STARTED && bg_pct == 7'd0 &&
        bg_opcode == $past({start_set, start_cmd})));

    // R3
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && bg_running) |=> (rsp_valid && rsp_code == RC_BUSY &&
        $stable(bg_opcode)));

    // R4
    pct_below_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bg_running |-> (bg_pct <= 7'd99));

    // R5
    finish_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bg_running) |-> (bg_pct == 7'd100 && bg_retcode == RC_SUCCESS &&
        done_pulse && done_opcode == bg_opcode));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R7
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_msix || irq_msi) |-> done_pulse);

    // R7
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_msix, irq_msi}));
endmodule

bind bgt_tracker bgt_tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .start_set   (start_set),
    .start_cmd   (start_cmd),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .bg_running  (bg_running),
    .bg_opcode   (bg_opcode),
    .bg_pct      (bg_pct),
    .bg_retcode  (bg_retcode),
    .done_pulse  (done_pulse),
    .done_opcode (done_opcode),
    .irq_msix    (irq_msix),
    .irq_msi     (irq_msi)
);

// File: tb/bgt_tracker_tb.sv
// Bench for bgt_tracker: directed corners plus seeded random commands.
module bgt_tracker_tb;
    localparam int RT_W = 24;
    localparam int UPD  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ms_tick = 1'b0;
    logic            start_req = 1'b0;
    logic [7:0]      start_set = '0;
    logic [7:0]      start_cmd = '0;
    logic [RT_W-1:0] start_runtime = '0;
    logic            msix_en = 1'b0;
    logic            msi_en = 1'b0;
    logic            rsp_valid;
    logic [15:0]     rsp_code;
    logic            bg_running;
    logic [15:0]     bg_opcode;
    logic [6:0]      bg_pct;
    logic [15:0]     bg_retcode;
    logic [7:0]      qry_status;
    logic            done_pulse;
    logic [15:0]     done_opcode;
    logic            irq_msix;
    logic            irq_msi;
    logic [4:0]      irq_vector;
    logic            cap_bg_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bgt_tracker #(.RT_W(RT_W), .UPD_MS(UPD)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pct(input int e, input int rt);
        int p;
        p = (e * 100) / rt;
        return (p > 99) ? 99 : p;
    endfunction

    task automatic do_tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic issue_start(input logic [7:0] s, input logic [7:0] c, input int rt, input bit tk);
        @(negedge clk);
        start_req = 1'b1; start_set = s; start_cmd = c;
        start_runtime = RT_W'(rt); ms_tick = tk;
        @(negedge clk);
        start_req = 1'b0; ms_tick = 1'b0;
    endtask

    // Run one command to completion; busy_at selects a tick after which an overlap is tried.
    task automatic run_cmd(input logic [7:0] s, input logic [7:0] c, input int rt_in,
                           input int busy_at, input bit xen, input bit ien);
        int rt;
        int prev;
        int ex;
        logic [15:0] op;
        msix_en = xen; msi_en = ien;
        op = {s, c};
        rt = (rt_in == 0) ? 1 : rt_in;
        issue_start(s, c, rt_in, 1'b0);
        chk(rsp_valid && rsp_code == 16'h0001, "R2 rsp", rsp_code, 1);
        chk(bg_running == 1'b1 && bg_opcode == op, "R2 opcode", bg_opcode, op);
        chk(bg_pct == 7'd0 && bg_retcode == 16'h0001, "R2 pct/ret", bg_pct, 0);
        prev = 0;
        for (int e = 1; e <= rt; e++) begin
            do_tick();
            if (e == rt) begin
                chk(!bg_running && bg_pct == 7'd100, "R5 pct", bg_pct, 100);
                chk(bg_retcode == 16'h0000, "R5 ret", bg_retcode, 0);
                chk(done_pulse && done_opcode == op, "R5 done_op", done_opcode, op);
                chk(irq_msix == xen, "R7 msix", irq_msix, xen);
                chk(irq_msi == (!xen && ien), "R7 msi", irq_msi, (!xen && ien));
                chk(qry_status == 8'd200, "R6 qry final", qry_status, 200);
            end else begin
                repeat (10) @(negedge clk);
                ex = (e % UPD == 0) ? exp_pct(e, rt) : prev;
                chk(bg_pct == 7'(ex) && bg_running, "R4 pct", bg_pct, ex);
                chk(qry_status == {7'(ex), 1'b1}, "R6 qry", qry_status, {7'(ex), 1'b1});
                prev = ex;
                if (e == busy_at) begin
                    issue_start(8'hA5, 8'h5A, 3, 1'b0);
                    chk(rsp_valid && rsp_code == 16'h0010, "R3 busy", rsp_code, 16'h0010);
                    chk(bg_opcode == op && bg_pct == 7'(ex) && bg_running, "R3 unchanged", bg_opcode, op);
                end
            end
        end
        @(negedge clk);
        chk(!done_pulse && !irq_msix && !irq_msi, "R5 single pulse", done_pulse, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk(!bg_running && bg_pct == 0 && bg_opcode == 0, "R1 state", bg_pct, 0);
        chk(bg_retcode == 0 && !done_pulse && !irq_msix && !irq_msi, "R1 flags", bg_retcode, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_vector == 5'd9 && cap_bg_irq, "R7 vector", irq_vector, 9);
        chk(qry_status == 8'd0, "R6 idle", qry_status, 0);
        // Directed: exact multiple and nonmultiple runtimes, all irq modes.
        run_cmd(8'h44, 8'h00, 35, 20, 1'b1, 1'b1);
        run_cmd(8'h43, 8'h04, 20, 5, 1'b0, 1'b1);
        run_cmd(8'h12, 8'h34, 7, 2, 1'b0, 1'b0);
        // R8: runtime 0 behaves as 1 ms.
        run_cmd(8'h01, 8'h02, 0, 0, 1'b1, 1'b0);
        // R9: tick coinciding with start is not counted.
        issue_start(8'h77, 8'h01, 2, 1'b1);
        chk(bg_running && bg_opcode == 16'h7701, "R9 start", bg_opcode, 16'h7701);
        do_tick();
        chk(bg_running && !done_pulse, "R9 first tick", bg_running, 1);
        do_tick();
        chk(!bg_running && done_pulse, "R9 finish", bg_running, 0);
        // Random commands.
        for (int i = 0; i < 8; i++) begin
            int rt;
            rt = 1 + int'($urandom_range(44));
            run_cmd(8'($urandom), 8'($urandom), rt, int'($urandom_range(rt)),
                    1'($urandom), 1'($urandom));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule